// File: doc/BRIEF.md
# Triple Match Timer with Interrupt Aggregation

This block contains three independent 32-bit counters, each reached through a small word-addressed register bus. Each counter has a software-writable live count, a reload value, and two compare values. Each counter can be set to count up or down. It steps on every bus clock, or once per rising edge of its own external tick input. The external tick passes through a two-flop synchroniser and an edge detector before it is used.

Each counter produces three events: compare 1, compare 2, and wrap. When the count wraps, the counter loads its reload value, so a timer can produce a periodic event with no software involvement. All nine events collect into one sticky status register. A shared mask register filters the events, and a per-timer interrupt-enable bit in the control register gates each timer's interrupt output. Software clears status bits by writing ones to them.

Top module: `tri_match_timer`

## Requirements
- R1: After synchronous active-low reset, all counts, reload values, compare values, the control register and the status register read zero. The mask register reads 0x1FF and every irq bit is low.
- R2: Word offsets are as follows. Timer t (t = 0..2) has its count at 16t, its reload at 16t+4, compare 1 at 16t+8 and compare 2 at 16t+12. Control is at 0x30, status at 0x34 and mask at 0x38. A read of any mapped register returns its present value in the same cycle. A read of any other or misaligned offset returns zero, and a write to one changes nothing.
- R3: Control bit 3t enables timer t. A timer whose control bit 9+t is 1 adds one per step. With clock-select bit 3t+1 at 0, the timer steps on every clock in which it is enabled. While bit 3t is 0 the count holds its value.
- R4: A step taken by an up-counting timer from 0xFFFFFFFF loads the reload value and sets status bit 3t+2.
- R5: With control bit 9+t at 0 the timer subtracts one per step. A step taken from zero loads the reload value and sets status bit 3t+2.
- R6: A step taken from a count equal to compare 1 sets status bit 3t. A step taken from a count equal to compare 2 sets status bit 3t+1.
- R7: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. When an event and a clear of the same bit fall in one cycle, the bit stays set.
- R8: irq[t] is high when control bit 3t+2 is 1 and at least one of status bits 3t..3t+2 has its mask bit at 0. A mask bit of 1 blocks its status bit.
- R9: With clock-select bit 3t+1 at 1, timer t steps exactly once per rising edge of ext_tick[t], after synchronisation. It does not step on bus clocks while the tick input holds a steady level.
- R10: A bus write to a count register loads the written value at that clock edge and takes precedence over a step in the same cycle. Counting resumes from the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the addressed register |
| ext_tick | input | 3 | External tick for each timer, asynchronous |
| irq | output | 3 | Interrupt line for each timer |

## Verification
A write becomes visible at the clock edge that captures it. An enabled counter takes its first step on the edge after its enable bit is captured, and takes its last step on the edge that captures the disable. A window of N idle cycles between the two writes therefore yields exactly N+1 steps. The bench compares each window against a step-by-step model of the counter. Status bits rise on the same edge as the step that causes them, and irq follows the status and mask registers with no extra cycle, so both are sampled at the falling edge after the capturing write. External ticks need three edges to produce a step, so the bench keeps each tick level for three cycles and leaves slack before it stops the timer.

// File: rtl/tmt_pkg.sv
// Shared constants and types for the triple match timer.
// Assumes three control fields and three event sources per timer.
package tmt_pkg;
    localparam int EV_PER_TMR = 3;
    localparam int EV_M1      = 0;
    localparam int EV_M2      = 1;
    localparam int EV_OVF     = 2;
    localparam int CTL_FIELDS = 3;
    localparam int CTL_EN     = 0;
    localparam int CTL_CLK    = 1;
    localparam int CTL_IE     = 2;

    typedef struct packed {
        logic en;
        logic ext_clk;
        logic ie;
        logic up;
    } tmr_ctl_t;
endpackage

// File: rtl/tmt_tick_sync.sv
// Two-flop synchroniser plus rising-edge detector for an external tick.
// Assumes tick_in is asynchronous and stays high and low for at least two
// clocks each; the output is a one-clock pulse three edges after the rise.
module tmt_tick_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    output logic pulse
);
    logic s1, s2, s3;

    // Synchronise the tick and keep one delayed copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= tick_in;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // Rising edge of the synchronised level.
    always_comb pulse = s2 & ~s3;

    // R9
    sync_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/tmt_channel.sv
// One timer: live count, reload and two compare registers, step logic and
// event generation. Events are flagged from the value held before a step.
// Assumes ext_pulse is already synchronised to clk.
module tmt_channel import tmt_pkg::*; #(
    parameter int CNT_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  tmr_ctl_t              ctl,
    input  logic                  ext_pulse,
    input  logic                  wr_cnt,
    input  logic                  wr_rel,
    input  logic                  wr_m1,
    input  logic                  wr_m2,
    input  logic [CNT_W-1:0]      wdata,
    output logic [CNT_W-1:0]      count,
    output logic [CNT_W-1:0]      reload,
    output logic [CNT_W-1:0]      match1,
    output logic [CNT_W-1:0]      match2,
    output logic [EV_PER_TMR-1:0] ev
);
    localparam logic [CNT_W-1:0] TOP_V  = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ZERO_V = '0;
    localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

    logic             step;
    logic             at_end;
    logic [CNT_W-1:0] nxt;

    // A step happens on every enabled clock, or on tick pulses if selected.
    always_comb step = ctl.en & (ctl.ext_clk ? ext_pulse : 1'b1);

    // The terminal value depends on the counting direction.
    always_comb at_end = ctl.up ? (count == TOP_V) : (count == ZERO_V);

    // Next count value for a step: wrap to reload, else move by one.
    always_comb begin
        if (at_end)      nxt = reload;
        else if (ctl.up) nxt = count + ONE_V;
        else             nxt = count - ONE_V;
    end

    // Events raised by a step, judged on the pre-step count.
    always_comb begin
        ev         = '0;
        ev[EV_M1]  = step & (count == match1);
        ev[EV_M2]  = step & (count == match2);
        ev[EV_OVF] = step & at_end;
    end

    // Register updates; a bus write to the count beats a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            reload <= '0;
            match1 <= '0;
            match2 <= '0;
        end else begin
            if (wr_rel) reload <= wdata;
            if (wr_m1)  match1 <= wdata;
            if (wr_m2)  match2 <= wdata;
            if (wr_cnt)    count <= wdata;
            else if (step) count <= nxt;
        end
    end

    // R3
    cnt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl.en && !wr_cnt) |=> $stable(count));
    // R3
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && ctl.up && !wr_cnt && count != TOP_V)
        |=> (count - $past(count)) == ONE_V);
    // R4
    up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && ctl.up && !wr_cnt && count == TOP_V)
        |=> count == $past(reload));
    // R5
    down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ctl.up && !wr_cnt && count == ZERO_V)
        |=> count == $past(reload));
    // R10
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> count == $past(wdata));
endmodule

// File: rtl/tmt_irq.sv
// Sticky status, mask and per-timer interrupt gating for all timers.
// Assumes events are single-cycle strobes; set wins over a write-one clear.
module tmt_irq import tmt_pkg::*; #(
    parameter  int NUM_TIMERS = 3,
    localparam int EV_W       = EV_PER_TMR * NUM_TIMERS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [EV_W-1:0]       ev,
    input  logic                  sts_we,
    input  logic                  msk_we,
    input  logic [EV_W-1:0]       wbits,
    input  logic [NUM_TIMERS-1:0] ie,
    output logic [EV_W-1:0]       sts,
    output logic [EV_W-1:0]       msk,
    output logic [NUM_TIMERS-1:0] irq
);
    logic [EV_W-1:0] clr;

    // Bits that software asks to clear this cycle.
    always_comb clr = sts_we ? wbits : '0;

    // Status and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= '0;
            msk <= '1;
        end else begin
            sts <= (sts & ~clr) | ev;
            if (msk_we) msk <= wbits;
        end
    end

    // Per-timer interrupt: any unmasked status bit, gated by its enable.
    always_comb begin
        for (int t = 0; t < NUM_TIMERS; t++) begin
            irq[t] = ie[t] & (|(sts[EV_PER_TMR*t +: EV_PER_TMR] &
                                ~msk[EV_PER_TMR*t +: EV_PER_TMR]));
        end
    end

    for (genvar b = 0; b < EV_W; b++) begin : g_sts_chk
        // R7
        sts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ev[b] |=> sts[b]);
        // R7
        sts_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_we && wbits[b] && !ev[b]) |=> !sts[b]);
        // R7
        sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ev[b] && !(sts_we && wbits[b])) |=> sts[b] == $past(sts[b]));
    end

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_irq_chk
        // R8
        irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !ie[t] |-> !irq[t]);
        // R8
        irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((sts[EV_PER_TMR*t +: EV_PER_TMR] &
              ~msk[EV_PER_TMR*t +: EV_PER_TMR]) == '0) |-> !irq[t]);
    end
endmodule

// File: rtl/tri_match_timer.sv
// Top: register decode, control register, three timer channels with tick
// synchronisers, and the shared status/mask/interrupt unit.
// Assumes word-aligned single-cycle accesses; reads are combinational.
module tri_match_timer import tmt_pkg::*; #(
    parameter int NUM_TIMERS = 3,
    parameter int CNT_W      = 32,
    parameter int ADDR_W     = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_en,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [CNT_W-1:0]      bus_wdata,
    output logic [CNT_W-1:0]      bus_rdata,
    input  logic [NUM_TIMERS-1:0] ext_tick,
    output logic [NUM_TIMERS-1:0] irq
);
    localparam int EV_W    = EV_PER_TMR * NUM_TIMERS;
    localparam int CTL_W   = CTL_FIELDS * NUM_TIMERS + NUM_TIMERS;
    localparam int UP_BASE = CTL_FIELDS * NUM_TIMERS;
    localparam int IW      = ADDR_W - 2;
    localparam int REGS_PT = 4;
    localparam int IDX_CTL = REGS_PT * NUM_TIMERS;
    localparam int IDX_STS = IDX_CTL + 1;
    localparam int IDX_MSK = IDX_CTL + 2;

    logic [IW-1:0]         widx;
    logic                  aligned;
    logic                  wr_any;
    logic                  rd_any;
    logic                  hit;
    logic [CNT_W-1:0]      rd_val;
    logic [CTL_W-1:0]      ctrl_q;
    logic [EV_W-1:0]       ev_all;
    logic [EV_W-1:0]       sts;
    logic [EV_W-1:0]       msk;
    logic [NUM_TIMERS-1:0] ie_v;
    logic [NUM_TIMERS-1:0] tick_pulse;
    logic [CNT_W-1:0]      cnt_a [NUM_TIMERS];
    logic [CNT_W-1:0]      rel_a [NUM_TIMERS];
    logic [CNT_W-1:0]      m1_a  [NUM_TIMERS];
    logic [CNT_W-1:0]      m2_a  [NUM_TIMERS];

    // Decode the word index and the access kind.
    always_comb begin
        widx    = bus_addr[ADDR_W-1:2];
        aligned = (bus_addr[1:0] == 2'b00);
        wr_any  = bus_en & bus_we & aligned;
        rd_any  = bus_en & ~bus_we;
    end

    // Control register: enables, clock selects, irq enables, directions.
    always_ff @(posedge clk) begin
        if (!rst_n)                               ctrl_q <= '0;
        else if (wr_any && widx == IW'(IDX_CTL))  ctrl_q <= bus_wdata[CTL_W-1:0];
    end

    for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
        tmr_ctl_t ctl_t;
        logic     wc, wr, w1, w2;

        // Unpack this timer's control fields.
        always_comb begin
            ctl_t.en      = ctrl_q[CTL_FIELDS*t + CTL_EN];
            ctl_t.ext_clk = ctrl_q[CTL_FIELDS*t + CTL_CLK];
            ctl_t.ie      = ctrl_q[CTL_FIELDS*t + CTL_IE];
            ctl_t.up      = ctrl_q[UP_BASE + t];
            ie_v[t]       = ctl_t.ie;
        end

        // Per-register write strobes for this timer.
        always_comb begin
            wc = wr_any & (widx == IW'(REGS_PT*t + 0));
            wr = wr_any & (widx == IW'(REGS_PT*t + 1));
            w1 = wr_any & (widx == IW'(REGS_PT*t + 2));
            w2 = wr_any & (widx == IW'(REGS_PT*t + 3));
        end

        tmt_tick_sync u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_in (ext_tick[t]),
            .pulse   (tick_pulse[t])
        );

        tmt_channel #(.CNT_W(CNT_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .ctl       (ctl_t),
            .ext_pulse (tick_pulse[t]),
            .wr_cnt    (wc),
            .wr_rel    (wr),
            .wr_m1     (w1),
            .wr_m2     (w2),
            .wdata     (bus_wdata),
            .count     (cnt_a[t]),
            .reload    (rel_a[t]),
            .match1    (m1_a[t]),
            .match2    (m2_a[t]),
            .ev        (ev_all[EV_PER_TMR*t +: EV_PER_TMR])
        );
    end

    tmt_irq #(.NUM_TIMERS(NUM_TIMERS)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev_all),
        .sts_we (wr_any && widx == IW'(IDX_STS)),
        .msk_we (wr_any && widx == IW'(IDX_MSK)),
        .wbits  (bus_wdata[EV_W-1:0]),
        .ie     (ie_v),
        .sts    (sts),
        .msk    (msk),
        .irq    (irq)
    );

    // Read multiplexer over every mapped register.
    always_comb begin
        rd_val = '0;
        hit    = 1'b0;
        if (aligned) begin
            for (int t = 0; t < NUM_TIMERS; t++) begin
                if (widx == IW'(REGS_PT*t + 0)) begin rd_val = cnt_a[t]; hit = 1'b1; end
                if (widx == IW'(REGS_PT*t + 1)) begin rd_val = rel_a[t]; hit = 1'b1; end
                if (widx == IW'(REGS_PT*t + 2)) begin rd_val = m1_a[t];  hit = 1'b1; end
                if (widx == IW'(REGS_PT*t + 3)) begin rd_val = m2_a[t];  hit = 1'b1; end
            end
            if (widx == IW'(IDX_CTL)) begin rd_val = {{(CNT_W-CTL_W){1'b0}}, ctrl_q}; hit = 1'b1; end
            if (widx == IW'(IDX_STS)) begin rd_val = {{(CNT_W-EV_W){1'b0}}, sts};     hit = 1'b1; end
            if (widx == IW'(IDX_MSK)) begin rd_val = {{(CNT_W-EV_W){1'b0}}, msk};     hit = 1'b1; end
        end
    end

    // Drive read data only for a read access.
    always_comb bus_rdata = rd_any ? rd_val : '0;

    // R2
    rd_unmapped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && !hit) |-> bus_rdata == '0);
    // R1
    ctl_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (ctrl_q == '0 && sts == '0 && msk == '1));
endmodule

// File: tb/tri_match_timer_test.sv
module tri_match_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  ext_tick = '0;
    logic [2:0]  irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    tri_match_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_tick(ext_tick), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Called at a falling edge; captured at the next rising edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(req, d, exp);
    endtask

    // Model of one step: events from the pre-step value, then move or wrap.
    function automatic void model_step(input logic up, input logic [31:0] rel,
                                       input logic [31:0] m1, input logic [31:0] m2,
                                       inout logic [31:0] c, inout logic [2:0] ev);
        logic wrap;
        wrap = up ? (c == 32'hFFFF_FFFF) : (c == 32'h0);
        if (c == m1) ev[0] = 1'b1;
        if (c == m2) ev[1] = 1'b1;
        if (wrap)    ev[2] = 1'b1;
        c = wrap ? rel : (up ? c + 32'd1 : c - 32'd1);
    endfunction

    function automatic logic [2:0] exp_irq(input int t, input logic ie,
                                           input logic [2:0] ev, input logic [2:0] mk);
        logic [2:0] r;
        r = '0;
        r[t] = ie & (|(ev & ~mk));
        return r;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int unused_seed;
        unused_seed = $urandom(32'd7031);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        for (int a = 0; a < 12; a++) rd_chk("R1 reg", 8'(a*4), 32'h0);
        rd_chk("R1 ctrl", 8'h30, 32'h0);
        rd_chk("R1 status", 8'h34, 32'h0);
        rd_chk("R1 mask", 8'h38, 32'h1FF);
        check("R1 irq", {29'd0, irq}, 32'h0);

        // R2 map, readback and unmapped offsets
        wr(8'h24, 32'hA5A5_0001); wr(8'h28, 32'h5A5A_0002); wr(8'h2C, 32'h0F0F_0003);
        rd_chk("R2 reload t2", 8'h24, 32'hA5A5_0001);
        rd_chk("R2 cmp1 t2", 8'h28, 32'h5A5A_0002);
        rd_chk("R2 cmp2 t2", 8'h2C, 32'h0F0F_0003);
        rd_chk("R2 reload t0 untouched", 8'h04, 32'h0);
        wr(8'h30, 32'h0000_0E00);
        rd_chk("R2 ctrl", 8'h30, 32'h0000_0E00);
        wr(8'h30, 32'h0);
        wr(8'h3C, 32'hFFFF_FFFF); wr(8'h31, 32'hFFFF_FFFF); wr(8'h40, 32'hFFFF_FFFF);
        rd_chk("R2 unmapped 0x3C", 8'h3C, 32'h0);
        rd_chk("R2 misaligned 0x31", 8'h31, 32'h0);
        rd_chk("R2 unmapped 0x40", 8'h40, 32'h0);
        rd_chk("R2 ctrl after stray writes", 8'h30, 32'h0);
        rd_chk("R2 mask after stray writes", 8'h38, 32'h1FF);
        rd_chk("R2 count t0 after stray writes", 8'h00, 32'h0);

        // R4 up wrap
        wr(8'h00, 32'hFFFF_FFFE); wr(8'h04, 32'h100);
        wr(8'h30, 32'h201); repeat (2) @(negedge clk); wr(8'h30, 32'h200);
        rd_chk("R4 count after wrap", 8'h00, 32'h101);
        rd_chk("R4 overflow bit", 8'h34, 32'h004);
        wr(8'h34, 32'h1FF);

        // R5 down wrap and periodic compare
        wr(8'h10, 32'd1); wr(8'h14, 32'd7); wr(8'h18, 32'h55); wr(8'h1C, 32'h55);
        wr(8'h30, 32'h008); repeat (2) @(negedge clk); wr(8'h30, 32'h0);
        rd_chk("R5 count after down wrap", 8'h10, 32'd6);
        rd_chk("R5 overflow bit", 8'h34, 32'h020);
        wr(8'h34, 32'h1FF);
        wr(8'h20, 32'd3); wr(8'h24, 32'd3); wr(8'h28, 32'd0); wr(8'h2C, 32'hFFFF);
        wr(8'h30, 32'h040); repeat (8) @(negedge clk); wr(8'h30, 32'h0);
        rd_chk("R5 periodic count", 8'h20, 32'd2);
        rd_chk("R6 R5 periodic cmp1 and wrap", 8'h34, 32'h140);
        wr(8'h34, 32'h1FF);

        // R3 freeze while disabled
        repeat (5) @(negedge clk);
        rd_chk("R3 frozen count", 8'h20, 32'd2);

        // R7 set wins over clear in the same cycle
        wr(8'h00, 32'd0); wr(8'h04, 32'd0); wr(8'h08, 32'd5); wr(8'h0C, 32'h100);
        wr(8'h30, 32'h201); repeat (5) @(negedge clk);
        wr(8'h34, 32'h1FF); wr(8'h30, 32'h200);
        rd_chk("R7 set wins", 8'h34, 32'h001);
        wr(8'h34, 32'h0);
        rd_chk("R7 write zero keeps", 8'h34, 32'h001);

        // R8 gating by enable and mask
        wr(8'h38, 32'h1FE);
        check("R8 irq blocked by enable", {29'd0, irq}, 32'h0);
        wr(8'h30, 32'h004);
        check("R8 irq raised", {29'd0, irq}, 32'h1);
        wr(8'h38, 32'h1FF);
        check("R8 irq masked", {29'd0, irq}, 32'h0);
        wr(8'h34, 32'h001);
        rd_chk("R7 write one clears", 8'h34, 32'h0);
        wr(8'h30, 32'h0);

        // R10 write beats a step, then counting resumes
        wr(8'h00, 32'd0);
        wr(8'h30, 32'h201); repeat (3) @(negedge clk);
        wr(8'h00, 32'h1234); wr(8'h30, 32'h200);
        rd_chk("R10 count load and resume", 8'h00, 32'h1235);
        wr(8'h34, 32'h1FF);

        // R9 external tick on timer 1
        wr(8'h10, 32'd0); wr(8'h18, 32'hFFFF); wr(8'h1C, 32'hFFFF);
        wr(8'h30, 32'h418);
        repeat (10) @(negedge clk);
        for (int p = 0; p < 5; p++) begin
            ext_tick[1] = 1'b1; repeat (3) @(negedge clk);
            ext_tick[1] = 1'b0; repeat (3) @(negedge clk);
        end
        ext_tick[1] = 1'b1; repeat (8) @(negedge clk);
        wr(8'h30, 32'h0);
        ext_tick[1] = 1'b0;
        rd_chk("R9 one step per tick edge", 8'h10, 32'd6);
        wr(8'h34, 32'h1FF);

        // Constrained random windows checked against the step model
        for (int trial = 0; trial < 45; trial++) begin
            int t, n, mode;
            logic up, ie;
            logic [31:0] c, rel, m1, m2, ctl_on, ctl_off;
            logic [2:0] ev, mk;
            logic [8:0] mask;
            t    = trial % 3;
            up   = 1'($urandom % 2);
            ie   = 1'($urandom % 2);
            mode = $urandom % 3;
            c    = (mode == 0) ? 32'hFFFF_FFFF - ($urandom % 20) :
                   (mode == 1) ? ($urandom % 20) : $urandom;
            rel  = ($urandom % 2) ? ($urandom % 16) : $urandom;
            m1   = up ? c + ($urandom % 30) : c - ($urandom % 30);
            m2   = ($urandom % 2) ? rel : $urandom;
            mask = 9'($urandom);
            n    = $urandom % 40;
            wr(8'h30, 32'h0);
            wr(8'h34, 32'h1FF);
            wr(8'(16*t), c); wr(8'(16*t+4), rel); wr(8'(16*t+8), m1); wr(8'(16*t+12), m2);
            wr(8'h38, {23'd0, mask});
            ctl_off = (32'(up) << (9 + t)) | (32'(ie) << (3*t + 2));
            ctl_on  = ctl_off | (32'd1 << (3*t));
            wr(8'h30, ctl_on);
            repeat (n) @(negedge clk);
            wr(8'h30, ctl_off);
            ev = '0;
            for (int s = 0; s < n + 1; s++) model_step(up, rel, m1, m2, c, ev);
            mk = mask[3*t +: 3];
            rd_chk("R3 R4 R5 random count", 8'(16*t), c);
            rd_chk("R6 R4 R5 random status", 8'h34, {23'd0, 9'({6'd0, ev}) << (3*t)});
            check("R8 random irq", {29'd0, irq}, {29'd0, exp_irq(t, ie, ev, mk)});
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule